// File: doc/BRIEF.md
# Return Address Stack with Software-Visible Top Entry

This block keeps the return addresses of a small processor core. A call or an interrupt acknowledge pushes the address of the next instruction, and a return pops it. The pointer moves up before each store and down after each read. Pointer value 0 is the empty position and has no storage behind it. The storage holds 31 words of 21 bits, and the pointer is 5 bits wide.

Software reaches the stack through four byte-wide registers. One register shows the pointer and three sticky status flags. The other three registers show the top entry one byte at a time. With these, an operating system can copy the hardware stack into memory and later rebuild it. The flags report a full stack, a push that found no room, and a pop that found the stack empty.

Top module: `retstack`

## Requirements
- R1: After reset the pointer is 0, all three flags are clear, and every register reads 0.
- R2: A push while the pointer is below 31 first increments the pointer and then stores `push_addr_i` in the entry at the new pointer value. That value is then visible at `pop_addr_o` and through the top-of-stack registers.
- R3: During a pop, `pop_addr_o` shows the entry at the current pointer in the same cycle, and the pointer decrements at the clock edge. Entries come back last-in, first-out.
- R4: When `push_i` and `pop_i` are both high, only the push takes effect. A register write in a cycle with a push or a pop is ignored.
- R5: The full flag sets when a push moves the pointer to 31. It stays set until a status write with bit 7 low, or until reset.
- R6: A push while the pointer is 31 sets a sticky overflow flag and changes neither the pointer nor any stored entry.
- R7: A pop while the pointer is 0 sets a sticky underflow flag, leaves the pointer at 0, and drives 0 on `pop_addr_o`.
- R8: The status register is select code 0. Bit 7 is full, bit 6 is underflow, bit 5 is overflow, and bits 4:0 are the pointer. A write loads the pointer from bits 4:0 and clears each flag whose bit is 0. A flag whose bit is 1 keeps its value, and no write can set a flag.
- R9: Select code 1 maps to bits 7:0 of the entry at the pointer, select code 2 to bits 15:8, and select code 3 to bits 20:16 (read zero-padded in bits 4:0). A write to one of these codes replaces only that slice of the entry.
- R10: While the pointer is 0, the top-of-stack registers read 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Push request (call or interrupt acknowledge) |
| push_addr_i | input | 21 | Return address to store |
| pop_i | input | 1 | Pop request (return) |
| pop_addr_o | output | 21 | Entry at the current pointer; 0 when the pointer is 0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 low, 2 high, 3 upper |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |

## Verification
The hardest state to reach is the top boundary: 31 pushes with no pop, followed by one more push. Only that sequence produces full and overflow together while the storage must stay unchanged. The stimulus fills the stack in a loop and then reads the top entry after the extra push. It then uses a status write to move the pointer into the middle of the filled stack. Software edits the top entry byte by byte, and a pop must return the merged value. Pointer-zero cases (empty pops and ignored top-of-stack writes) and same-cycle push/pop/write collisions are driven directly.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_UP   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/retstack_ptr.sv
module retstack_ptr #(
  parameter int DEPTH = 31,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             stat_wr_i,
  input  logic [7:0]       stat_wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_nxt_o,
  output logic             push_ok_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             ovf_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             full_q, full_d, unf_q, unf_d, ovf_q, ovf_d;
  logic             do_pop, upd_en;

  assign do_pop = pop_i & ~push_i;
  assign upd_en = push_i | pop_i | stat_wr_i;

  always_comb begin
    ptr_d  = ptr_q;
    full_d = full_q;
    unf_d  = unf_q;
    ovf_d  = ovf_q;
    if (push_i) begin
      if (ptr_q == TOP) begin
        ovf_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
        if (ptr_q == TOP - 1'b1) full_d = 1'b1;
      end
    end else if (do_pop) begin
      if (ptr_q == '0) unf_d = 1'b1;
      else             ptr_d = ptr_q - 1'b1;
    end else if (stat_wr_i) begin
      ptr_d  = stat_wdata_i[PTR_W-1:0];
      full_d = full_q & stat_wdata_i[7];
      unf_d  = unf_q  & stat_wdata_i[6];
      ovf_d  = ovf_q  & stat_wdata_i[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (upd_en) begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      unf_q  <= unf_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_nxt_o = ptr_d;
  assign push_ok_o = push_i & (ptr_q != TOP);
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign ovf_o     = ovf_q;

  // R2: pre-increment on an accepted push
  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr_o != TOP) |=> ptr_o == $past(ptr_o) + 1'b1);
  // R3: post-decrement on a pop
  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && ptr_o != '0) |=> ptr_o == $past(ptr_o) - 1'b1);
  // R5: full after reaching the top
  p_full_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr_o == TOP - 1'b1) |=> (full_o && ptr_o == TOP));
  // R6: push at the top holds pointer and flags overflow
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && ptr_o == TOP) |=> (ovf_o && ptr_o == TOP));
  // R7: pop at zero holds pointer and flags underflow
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && ptr_o == '0) |=> (unf_o && ptr_o == '0));
  // R8: software write never sets a flag
  p_wr_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && !push_i && !pop_i && !ovf_o) |=> !ovf_o);
endmodule

// File: rtl/retstack_mem.sv
module retstack_mem #(
  parameter int W     = 21,
  parameter int DEPTH = 31,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ridx;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_i && waddr_i == PTR_W'(i + 1)) mem_q[i] <= wdata_i;
    end
  end

  assign ridx    = raddr_i - 1'b1;
  assign rdata_o = (raddr_i == '0) ? '0 : mem_q[ridx];
endmodule

// File: rtl/retstack.sv
module retstack
  import retstack_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DEPTH  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int UP_W  = ADDR_W - 16;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  reg_sel_e          sel;
  logic [PTR_W-1:0]  ptr, ptr_nxt, mem_waddr;
  logic              push_ok, full, unf, ovf;
  logic              sw_wr, stat_wr, tos_wr, mem_we;
  logic [ADDR_W-1:0] tos, merged, mem_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign sel     = reg_sel_e'(reg_sel_i);
  assign sw_wr   = reg_wr_i & ~push_i & ~pop_i;
  assign stat_wr = sw_wr & (sel == SEL_STAT);
  assign tos_wr  = sw_wr & (sel != SEL_STAT) & (ptr != '0);

  retstack_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_core_n), .push_i(push_i), .pop_i(pop_i),
    .stat_wr_i(stat_wr), .stat_wdata_i(reg_wdata_i),
    .ptr_o(ptr), .ptr_nxt_o(ptr_nxt), .push_ok_o(push_ok),
    .full_o(full), .unf_o(unf), .ovf_o(ovf)
  );

  always_comb begin
    merged = tos;
    case (sel)
      SEL_LO:  merged[7:0]         = reg_wdata_i;
      SEL_HI:  merged[15:8]        = reg_wdata_i;
      SEL_UP:  merged[ADDR_W-1:16] = reg_wdata_i[UP_W-1:0];
      default: merged              = tos;
    endcase
  end

  assign mem_we    = push_ok | tos_wr;
  assign mem_waddr = push_ok ? ptr_nxt : ptr;
  assign mem_wdata = push_ok ? push_addr_i : merged;

  retstack_mem #(.W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(ptr), .rdata_o(tos)
  );

  assign pop_addr_o = tos;

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_STAT: begin
        reg_rdata_o[7]         = full;
        reg_rdata_o[6]         = unf;
        reg_rdata_o[5]         = ovf;
        reg_rdata_o[PTR_W-1:0] = ptr;
      end
      SEL_LO:  reg_rdata_o = tos[7:0];
      SEL_HI:  reg_rdata_o = tos[15:8];
      default: reg_rdata_o[UP_W-1:0] = tos[ADDR_W-1:16];
    endcase
  end

  // R2: pushed address appears on the output after the push
  p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    push_ok |=> pop_addr_o == $past(push_addr_i));
  // R7: empty pop yields address zero
  p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pop_i && !push_i && ptr == '0) |-> pop_addr_o == '0);
  // R10: top-of-stack write at pointer zero leaves reads at zero
  p_tos_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ptr == '0 && reg_wr_i && sel != SEL_STAT && !push_i && !pop_i)
      |=> (ptr == '0 && pop_addr_o == '0));
  // R4: a register write during a push leaves the flags untouched by software
  p_push_beats_wr_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (push_i && reg_wr_i && full) |=> full);
endmodule

// File: tb/retstack_test.sv
`timescale 1ns/1ps
module retstack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic [20:0] push_addr_i = '0;
  logic        pop_i = 1'b0;
  logic [20:0] pop_addr_o;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;

  always #2.5 clk = ~clk;

  retstack uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // scoreboard queues: kind 0 = register read, 1 = pop address
  logic [20:0] q_val[$];
  bit          q_kind[$];
  string       q_tag[$];

  // reference model
  logic [20:0] m_mem[32];
  int          m_ptr;
  bit          m_full, m_unf, m_ovf;

  function automatic logic [20:0] m_tos();
    return (m_ptr == 0) ? 21'd0 : m_mem[m_ptr];
  endfunction

  function automatic logic [7:0] m_read(int sel);
    logic [20:0] t = m_tos();
    case (sel)
      0:       return {m_full, m_unf, m_ovf, 5'(m_ptr)};
      1:       return t[7:0];
      2:       return t[15:8];
      default: return {3'b000, t[20:16]};
    endcase
  endfunction

  task automatic expect_val(bit kind, logic [20:0] v, string tag);
    q_val.push_back(v);
    q_kind.push_back(kind);
    q_tag.push_back(tag);
  endtask

  task automatic step(bit push, logic [20:0] addr, bit pop, bit wr,
                      int sel, logic [7:0] wd, string tag);
    @(posedge clk); #1;
    push_i = push; push_addr_i = addr; pop_i = pop;
    reg_wr_i = wr; reg_sel_i = 2'(sel); reg_wdata_i = wd;
    expect_val(1'b0, 21'(m_read(sel)), tag);
    if (pop) expect_val(1'b1, m_tos(), tag);
    if (push) begin
      if (m_ptr == 31) m_ovf = 1;
      else begin
        m_ptr++;
        m_mem[m_ptr] = addr;
        if (m_ptr == 31) m_full = 1;
      end
    end else if (pop) begin
      if (m_ptr == 0) m_unf = 1;
      else m_ptr--;
    end else if (wr) begin
      if (sel == 0) begin
        m_ptr = int'(wd[4:0]);
        m_full = m_full & wd[7];
        m_unf  = m_unf  & wd[6];
        m_ovf  = m_ovf  & wd[5];
      end else if (m_ptr != 0) begin
        case (sel)
          1: m_mem[m_ptr][7:0]   = wd;
          2: m_mem[m_ptr][15:8]  = wd;
          default: m_mem[m_ptr][20:16] = wd[4:0];
        endcase
      end
    end
  endtask

  task automatic rd(int sel, string tag);
    step(0, '0, 0, 0, sel, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    push_i = 0; pop_i = 0; reg_wr_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    m_ptr = 0; m_full = 0; m_unf = 0; m_ovf = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_val.size() > 0) begin
      logic [20:0] exp_v, act_v;
      bit          k;
      string       t;
      exp_v = q_val.pop_front();
      k     = q_kind.pop_front();
      t     = q_tag.pop_front();
      act_v = k ? pop_addr_o : 21'(reg_rdata_o);
      vectors++;
      if (act_v !== exp_v) begin
        miscompares++;
        $display("FAIL %s %s actual=%h expected=%h", t,
                 k ? "pop_addr" : "reg_rdata", act_v, exp_v);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int s = 0; s < 4; s++) rd(s, "R1");
    // R2 push and R9 byte views
    step(1, 21'h12345, 0, 0, 0, 8'h00, "R2");
    rd(0, "R2");
    rd(1, "R9"); rd(2, "R9"); rd(3, "R9");
    step(1, 21'h0ABCD, 0, 0, 0, 8'h00, "R2");
    step(1, 21'h1FFFFF, 0, 0, 0, 8'h00, "R2");
    // R3 LIFO pops
    step(0, '0, 1, 0, 0, 8'h00, "R3");
    step(0, '0, 1, 0, 0, 8'h00, "R3");
    step(0, '0, 1, 0, 0, 8'h00, "R3");
    rd(0, "R3");
    // R7 empty pops
    step(0, '0, 1, 0, 0, 8'h00, "R7");
    rd(0, "R7");
    step(0, '0, 1, 0, 1, 8'h00, "R7");
    // R8 clear underflow only
    step(0, '0, 0, 1, 0, 8'hA0, "R8");
    rd(0, "R8");
    // R10 write at pointer zero ignored
    step(0, '0, 0, 1, 1, 8'h55, "R10");
    step(0, '0, 0, 1, 3, 8'h1F, "R10");
    rd(1, "R10"); rd(3, "R10");
    // R4 simultaneous push and pop, write during push
    step(1, 21'h00777, 1, 0, 1, 8'h00, "R4");
    rd(1, "R4"); rd(0, "R4");
    step(1, 21'h0BEEF, 0, 1, 0, 8'h00, "R4");
    rd(0, "R4");
    step(0, '0, 1, 1, 1, 8'h99, "R4");
    rd(1, "R4"); rd(0, "R4");
    // R5 fill to the top
    while (m_ptr < 31) step(1, 21'(32'h1000 * (m_ptr + 3) + m_ptr), 0, 0, 0, 8'h00, "R5");
    rd(0, "R5");
    // R6 overflow push
    step(1, 21'h00001, 0, 0, 1, 8'h00, "R6");
    rd(0, "R6"); rd(1, "R6"); rd(2, "R6"); rd(3, "R6");
    // R8 move pointer and clear all flags
    step(0, '0, 0, 1, 0, 8'h05, "R8");
    rd(0, "R8");
    // R9 byte writes, then pop the merged word
    step(0, '0, 0, 1, 1, 8'hC3, "R9");
    step(0, '0, 0, 1, 2, 8'h3C, "R9");
    step(0, '0, 0, 1, 3, 8'h1A, "R9");
    rd(1, "R9"); rd(2, "R9"); rd(3, "R9");
    step(0, '0, 1, 0, 2, 8'h00, "R9");
    rd(1, "R3");
    // R8 a keep bit cannot set a clear flag
    step(0, '0, 0, 1, 0, 8'h9E, "R8");
    rd(0, "R8");
    // R1 reset again mid-stream
    do_reset();
    for (int s = 0; s < 4; s++) rd(s, "R1");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule